// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and folds the product into an internal accumulator in the same clock edge that the operand strobe is seen. A mode input picks between two accumulate behaviours. In the narrow mode the running sum is held to 32 bits and clamps at the signed limits. In the wide mode the sum runs over 42 bits and wraps.

A clear command zeroes the accumulator and the overflow flag. A load command writes a 32-bit word from a general register into the accumulator, sign-extended over the upper bits. A store command returns the contents to the register side as two 32-bit words one cycle later. When more than one command arrives in a cycle, the priority is clear, then load, then accumulate. A store may share a cycle with any of them and always returns the value held before that cycle's update.

Top module: `mac_unit`

## Requirements
- R1: After reset, the accumulator holds zero, `ovfFlag` is 0 and `stValid` is 0.
- R2: In wide mode (`satMode`=0), a cycle with `opValid`=1 adds the signed 32-bit product `opA`×`opB`, sign-extended to 42 bits, to the accumulator modulo 2^42.
- R3: In saturating mode (`satMode`=1), the low 32 bits of the accumulator are taken as a signed value and the product is added to them. A sum above 0x7FFFFFFF is replaced by 0x7FFFFFFF, and a sum below -2^31 is replaced by 0x80000000. The 32-bit result is then stored sign-extended to 42 bits.
- R4: `ovfFlag` goes to 1 in the cycle after any saturating accumulate that clamps. It stays at 1 through later accumulates, loads and stores, and only a clear returns it to 0.
- R5: `clrCmd`=1 sets all 42 accumulator bits and `ovfFlag` to zero on the next edge.
- R6: When `clrCmd` is 1, any `ldCmd` or `opValid` in the same cycle has no effect.
- R7: `ldCmd`=1 (without clear) sets the accumulator to `ldData` sign-extended from bit 31 to 42 bits, and an `opValid` in the same cycle is ignored.
- R8: `stCmd`=1 makes `stValid` 1 in the next cycle. In that cycle `stLow` holds accumulator bits 31:0 and `stHigh` holds bits 41:32 sign-extended to 32 bits, both taken from the value before the `stCmd` cycle's own update.
- R9: A cycle with `opValid`, `clrCmd` and `ldCmd` all 0 leaves the accumulator unchanged, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operands present; accumulate this cycle |
| opA | input | 16 | Signed multiplicand |
| opB | input | 16 | Signed multiplier |
| satMode | input | 1 | 1 = 32-bit saturating, 0 = 42-bit wrapping |
| clrCmd | input | 1 | Clear accumulator and overflow flag |
| ldCmd | input | 1 | Load accumulator from `ldData` |
| ldData | input | 32 | Load word from a general register |
| stCmd | input | 1 | Request read-back of the accumulator |
| stValid | output | 1 | Read-back words are valid |
| stLow | output | 32 | Accumulator bits 31:0 |
| stHigh | output | 32 | Accumulator bits 41:32, sign-extended |
| ovfFlag | output | 1 | Sticky saturation indicator |

## Verification
Long runs of full-scale positive products in wide mode carry the sum past 32 bits and then past 2^41. This separates a true 42-bit wrap from a 32-bit truncation or a stray clamp. Loads close to each signed limit, followed by a product of the opposite or the same sign, reach the positive clamp, the negative clamp and an in-range result. Comparing these shows whether the saturation tests the right carry bits. Same-cycle mixes of clear, load, accumulate and store reveal the command priority and whether a store reads the value before or after the update. A long random mix of operands and modes then covers sign combinations that the directed cases miss.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Strobes from control to datapath, one cycle wide, already prioritised.
  typedef struct packed {
    logic clr;   // zero accumulator and sticky flag
    logic ld;    // load from register word
    logic acc;   // add product
    logic sat;   // saturating flavour of the add
    logic st;    // capture read-back words
  } macStrobe_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       opValid,
  input  logic       satMode,
  input  logic       clrCmd,
  input  logic       ldCmd,
  input  logic       stCmd,
  output macStrobe_t strobe
);

  // Priority: clear beats load beats accumulate; store is independent.
  always_comb begin
    strobe     = '0;
    strobe.st  = stCmd;
    strobe.sat = satMode;
    if (clrCmd) begin
      strobe.clr = 1'b1;
    end else if (ldCmd) begin
      strobe.ld = 1'b1;
    end else if (opValid) begin
      strobe.acc = 1'b1;
    end
  end

endmodule

// File: rtl/mac_sat_add.sv
module mac_sat_add #(
  parameter int ACC_W  = 42,
  parameter int SAT_W  = 32,
  parameter int PROD_W = 32
) (
  input  logic [ACC_W-1:0]  accIn,
  input  logic [PROD_W-1:0] prodIn,
  input  logic              satMode,
  output logic [ACC_W-1:0]  sumOut,
  output logic              satHit
);

  localparam int NW = SAT_W + 1;

  logic [ACC_W-1:0] wideProd;
  logic [ACC_W-1:0] wideSum;
  logic [NW-1:0]    narrowAcc;
  logic [NW-1:0]    narrowProd;
  logic [NW-1:0]    narrowSum;
  logic             posOv;
  logic             negOv;
  logic [SAT_W-1:0] clamped;

  always_comb begin
    wideProd   = {{(ACC_W-PROD_W){prodIn[PROD_W-1]}}, prodIn};
    wideSum    = accIn + wideProd;

    narrowAcc  = {accIn[SAT_W-1], accIn[SAT_W-1:0]};
    narrowProd = {{(NW-PROD_W){prodIn[PROD_W-1]}}, prodIn};
    narrowSum  = narrowAcc + narrowProd;

    posOv = (narrowSum[NW-1:NW-2] == 2'b01);
    negOv = (narrowSum[NW-1:NW-2] == 2'b10);

    if (posOv)      clamped = {1'b0, {(SAT_W-1){1'b1}}};
    else if (negOv) clamped = {1'b1, {(SAT_W-1){1'b0}}};
    else            clamped = narrowSum[SAT_W-1:0];

    if (satMode) begin
      sumOut = {{(ACC_W-SAT_W){clamped[SAT_W-1]}}, clamped};
      satHit = posOv | negOv;
    end else begin
      sumOut = wideSum;
      satHit = 1'b0;
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 42,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  macStrobe_t        strobe,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [DATA_W-1:0] ldData,
  output logic [ACC_W-1:0]  accVal,
  output logic              ovfFlag,
  output logic              stValid,
  output logic [DATA_W-1:0] stLow,
  output logic [DATA_W-1:0] stHigh
);

  localparam int PROD_W = 2 * OP_W;
  localparam int HIGH_W = ACC_W - DATA_W;

  logic signed [PROD_W-1:0] extA;
  logic signed [PROD_W-1:0] extB;
  logic        [PROD_W-1:0] product;
  logic        [ACC_W-1:0]  addResult;
  logic                     addSat;
  logic        [ACC_W-1:0]  accQ;
  logic        [ACC_W-1:0]  accNext;
  logic                     ovfQ;
  logic                     ovfNext;

  always_comb begin
    extA    = {{OP_W{opA[OP_W-1]}}, opA};
    extB    = {{OP_W{opB[OP_W-1]}}, opB};
    product = extA * extB;
  end

  mac_sat_add #(
    .ACC_W (ACC_W),
    .SAT_W (DATA_W),
    .PROD_W(PROD_W)
  ) uAdd (
    .accIn  (accQ),
    .prodIn (product),
    .satMode(strobe.sat),
    .sumOut (addResult),
    .satHit (addSat)
  );

  always_comb begin
    accNext = accQ;
    ovfNext = ovfQ;
    if (strobe.clr) begin
      accNext = '0;
      ovfNext = 1'b0;
    end else if (strobe.ld) begin
      accNext = {{HIGH_W{ldData[DATA_W-1]}}, ldData};
    end else if (strobe.acc) begin
      accNext = addResult;
      ovfNext = ovfQ | addSat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      ovfQ <= 1'b0;
    end else begin
      accQ <= accNext;
      ovfQ <= ovfNext;
    end
  end

  // Read-back snapshot of the pre-update contents.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stValid <= 1'b0;
      stLow   <= '0;
      stHigh  <= '0;
    end else begin
      stValid <= strobe.st;
      if (strobe.st) begin
        stLow  <= accQ[DATA_W-1:0];
        stHigh <= {{(DATA_W-HIGH_W){accQ[ACC_W-1]}}, accQ[ACC_W-1:DATA_W]};
      end
    end
  end

  assign accVal  = accQ;
  assign ovfFlag = ovfQ;

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 42,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic              satMode,
  input  logic              clrCmd,
  input  logic              ldCmd,
  input  logic [DATA_W-1:0] ldData,
  input  logic              stCmd,
  output logic              stValid,
  output logic [DATA_W-1:0] stLow,
  output logic [DATA_W-1:0] stHigh,
  output logic              ovfFlag
);

  macStrobe_t       strobe;
  logic [ACC_W-1:0] accVal;

  mac_ctrl uCtrl (
    .opValid(opValid),
    .satMode(satMode),
    .clrCmd (clrCmd),
    .ldCmd  (ldCmd),
    .stCmd  (stCmd),
    .strobe (strobe)
  );

  mac_datapath #(
    .OP_W  (OP_W),
    .ACC_W (ACC_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .ldData (ldData),
    .accVal (accVal),
    .ovfFlag(ovfFlag),
    .stValid(stValid),
    .stLow  (stLow),
    .stHigh (stHigh)
  );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int ACC_W  = 42,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic              satMode,
  input logic              clrCmd,
  input logic              ldCmd,
  input logic              stCmd,
  input logic [DATA_W-1:0] ldData,
  input logic [ACC_W-1:0]  accVal,
  input logic              ovfFlag,
  input logic              stValid,
  input logic [DATA_W-1:0] stLow
);

  localparam int HIGH_W = ACC_W - DATA_W;

  // R5 and R6: clear wins and zeroes everything
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    clrCmd |=> (accVal == '0) && !ovfFlag);

  // R7: load takes the sign-extended register word
  p_load_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ldCmd && !clrCmd) |=>
      (accVal == {{HIGH_W{$past(ldData[DATA_W-1])}}, $past(ldData)}));

  // R9: idle cycle keeps the accumulator
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !clrCmd && !ldCmd) |=> $stable(accVal));

  // R3: saturating accumulate leaves a 32-bit signed value
  p_sat_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && satMode && !clrCmd && !ldCmd) |=>
      ((accVal[ACC_W-1:DATA_W-1] == '0) || (accVal[ACC_W-1:DATA_W-1] == '1)));

  // R4: sticky flag survives anything but clear
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrCmd) |=> ovfFlag);

  // R8: read-back one cycle after request, pre-update low word
  p_store_timing_r8: assert property (@(posedge clk) disable iff (!rstN)
    stCmd |=> stValid && (stLow == $past(accVal[DATA_W-1:0])));

  p_store_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stCmd |=> !stValid);

endmodule

bind mac_unit mac_unit_chk #(
  .ACC_W (ACC_W),
  .DATA_W(DATA_W)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .opValid(opValid),
  .satMode(satMode),
  .clrCmd (clrCmd),
  .ldCmd  (ldCmd),
  .stCmd  (stCmd),
  .ldData (ldData),
  .accVal (accVal),
  .ovfFlag(ovfFlag),
  .stValid(stValid),
  .stLow  (stLow)
);

// File: tb/mac_unit_test.sv
module mac_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        satMode = 1'b0;
  logic        clrCmd = 1'b0;
  logic        ldCmd = 1'b0;
  logic [31:0] ldData = '0;
  logic        stCmd = 1'b0;
  logic        stValid;
  logic [31:0] stLow;
  logic [31:0] stHigh;
  logic        ovfFlag;

  always #2 clk = ~clk;  // 250 MHz

  mac_unit uut (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .opA    (opA),
    .opB    (opB),
    .satMode(satMode),
    .clrCmd (clrCmd),
    .ldCmd  (ldCmd),
    .ldData (ldData),
    .stCmd  (stCmd),
    .stValid(stValid),
    .stLow  (stLow),
    .stHigh (stHigh),
    .ovfFlag(ovfFlag)
  );

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    logic        ov;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int       checks = 0;
  int       fails  = 0;
  bit       done   = 1'b0;

  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic [41:0] mAcc = '0;
  logic        mOvf = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, update the model, queue the expectation.
  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                      input logic sat, input logic clr, input logic ld,
                      input logic [31:0] ldd, input logic st, input string tag);
    int     p;
    longint s;
    expItem_t it;
    opValid = v; opA = a; opB = b; satMode = sat;
    clrCmd = clr; ldCmd = ld; ldData = ldd; stCmd = st;
    it.lo  = mAcc[31:0];
    it.hi  = {{22{mAcc[41]}}, mAcc[41:32]};
    it.tag = tag;
    if (clr) begin
      mAcc = '0;
      mOvf = 1'b0;
    end else if (ld) begin
      mAcc = {{10{ldd[31]}}, ldd};
    end else if (v) begin
      p = int'($signed(a)) * int'($signed(b));
      if (sat) begin
        s = longint'($signed(mAcc[31:0])) + longint'(p);
        if (s > SMAX) begin
          s = SMAX; mOvf = 1'b1;
        end else if (s < SMIN) begin
          s = SMIN; mOvf = 1'b1;
        end
        mAcc = {{10{s[31]}}, s[31:0]};
      end else begin
        mAcc = mAcc + {{10{p[31]}}, p};
      end
    end
    it.ov = mOvf;
    if (st) expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic acc(input logic [15:0] a, input logic [15:0] b, input logic sat);
    step(1'b1, a, b, sat, 1'b0, 1'b0, '0, 1'b0, "R2");
  endtask

  task automatic store(input string tag);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b1, tag);
  endtask

  task automatic clear();
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R5");
  endtask

  task automatic load(input logic [31:0] d);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, d, 1'b0, "R7");
  endtask

  // Monitor: compare read-back words against the scoreboard.
  always @(negedge clk) begin
    if (rstN && stValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 unexpected stValid actual=1 expected=0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, stLow, e.lo, "stLow");
        check(e.tag, stHigh, e.hi, "stHigh");
        check(e.tag, {31'b0, ovfFlag}, {31'b0, e.ov}, "ovfFlag");
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {31'b0, stValid}, 32'd0, "stValid");
    check("R1", {31'b0, ovfFlag}, 32'd0, "ovfFlag");
    rstN = 1'b1;
    @(negedge clk);
    store("R1");

    // R2: wide accumulate of mixed signs, then crossing 32 bits and 2^41
    acc(16'h7FFF, 16'h7FFF, 1'b0);
    acc(16'h8000, 16'h7FFF, 1'b0);
    acc(16'hFFFF, 16'h0003, 1'b0);
    store("R2");
    for (int i = 0; i < 40; i++) acc(16'h8000, 16'h8000, 1'b0);
    store("R2");
    for (int i = 0; i < 2100; i++) acc(16'h8000, 16'h8000, 1'b0);
    store("R2");

    // R5: clear of a wide value
    clear();
    store("R5");

    // R3, R4: positive clamp then sticky flag
    load(32'h7FFF0000);
    acc(16'h7FFF, 16'h7FFF, 1'b1);
    store("R3");
    acc(16'hFFFF, 16'h0001, 1'b1);
    store("R4");
    load(32'h00000010);
    store("R4");
    clear();
    store("R4");

    // R3: negative clamp, then an in-range saturating add
    load(32'h80000100);
    acc(16'h8000, 16'h7FFF, 1'b1);
    store("R3");
    load(32'h12345678);
    acc(16'h1234, 16'hFEDC, 1'b1);
    store("R3");

    // R6: clear beats load and accumulate
    step(1'b1, 16'h7FFF, 16'h7FFF, 1'b0, 1'b1, 1'b1, 32'hDEADBEEF, 1'b0, "R6");
    store("R6");

    // R7: negative load sign-extends; load beats accumulate
    step(1'b1, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b1, 32'h80000000, 1'b0, "R7");
    store("R7");

    // R9: idle cycles with live operands
    step(1'b0, 16'h7FFF, 16'h8000, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b0, "R9");
    step(1'b0, 16'h1234, 16'h4321, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, "R9");
    store("R9");

    // R8: store shares a cycle with accumulate and with clear
    step(1'b1, 16'h4000, 16'h4000, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R8");
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b1, "R8");
    store("R8");

    // R2/R3 random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], 16'($urandom), 16'($urandom), r[2],
           (r[7:3] == 5'd0), (r[12:8] == 5'd1), $urandom, (r[14:13] == 2'd0),
           r[2] ? "R3" : "R2");
    end
    store("R2");
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R8");
    @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R8 missing stores actual=%0d expected=0", expQ.size());
    end
    finishRun();
  end

endmodule